// File: doc/BRIEF.md
# Serial Frame Aligner with Lock Detection

This block sits behind a bit sampler that delivers one bit per clock of a framed serial stream. Every frame is 20 bits long: a high start bit, 18 payload bits and a low stop bit. As a result, the only 0-to-1 step that recurs at a fixed position from frame to frame is the one from a stop bit into the next start bit. The aligner watches all 20 bit offsets at once. For each offset it counts how many frames in a row have shown a rising step there. It declares alignment only when exactly one offset has been consistent long enough and no other offset is repeating.

Once aligned, the block extracts each payload word and presents it with a one-cycle strobe. It drives an active-low lock flag. It keeps checking the start-bit step every frame, and gives up alignment after a run of frames in which that step is missing. When it gives up, it raises a one-cycle loss pulse, so that downstream logic can throw away or request again the last few words.

Two controls gate the block. An active-low power control clears all alignment state and silences every output. An output enable quiets only the word path and leaves alignment running.

Sync frames make lock time bounded. A sync frame carries nine ones followed by nine zeros, so it contains one rising step per frame. Varying payload data also lets the block lock, provided no second rising step recurs at a fixed offset.

Top module: `frame_align_lock`

## Requirements
- R1: Payload order. The payload bit received first after the start bit appears on `word_o[0]`, and the last one on `word_o[17]`. `word_stb` pulses once per frame, one cycle after the stop bit is sampled, and strobes are at least 20 cycles apart.
- R2: Lock timing. Lock is not declared before an offset has shown a rising step in 4 consecutive frames. A stream of sync frames is locked within 5 frames.
- R3: Lock on varying data. A stream whose payload carries a single one that moves to a new bit in every frame still reaches lock.
- R4: No lock on a repeating second step. While a second offset repeats a rising step in at least 2 consecutive frames, the flag stays unlocked. Lock follows once only one repeating step remains.
- R5: Single miss tolerated. One frame with no rising step at the locked offset leaves lock in place.
- R6: Loss of lock. Two consecutive frames with no rising step at the locked offset raise `lock_n` and produce exactly one single-cycle `lock_lost` pulse, in the same cycle that `lock_n` rises.
- R7: Flag polarity. `lock_n` is 0 while aligned and 1 otherwise. `word_stb` never pulses while `lock_n` is 1.
- R8: Output enable. While `rx_en` is 0, `word_o` reads 0 and `word_stb` stays 0, and the lock state is kept. When `rx_en` returns to 1, words resume at the same alignment without any relock.
- R9: Power control. In the same cycle that `rx_pwr_n` is 0, `lock_n` reads 1, `word_stb` reads 0 and `word_o` reads 0.
- R10: Restart after power-down. Raising `rx_pwr_n` again puts the block into hunting with all counts cleared, so lock is not present 2 frames afterwards.
- R11: Reset state. After reset, `lock_n` is 1, and `word_stb`, `lock_lost` and `word_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pwr_n | input | 1 | Active-low power control; when 0, state is cleared and outputs are silenced |
| rx_en | input | 1 | Output enable for the word path |
| ser_bit | input | 1 | Sampled serial bit |
| word_o | output | DATA_W (18) | Extracted payload word |
| word_stb | output | 1 | One-cycle strobe marking a new word |
| lock_n | output | 1 | Alignment flag, 0 while locked |
| lock_lost | output | 1 | One-cycle pulse when lock is dropped for missing steps |

## Verification
The bench targets a stream with two recurring rising steps. A design that locked on the first offset to saturate would lock there on an arbitrary boundary; this design must instead stay unlocked until the second step stops. The bench also sends a single empty frame, then a pair of them. An off-by-one in the miss counter would either drop lock on the lone miss or hold lock through the pair. Payload carrying a walking one leaves a short-lived step at a new offset in every frame, so a blocking rule that counted one-frame steps would never lock. Toggling `rx_en` and `rx_pwr_n` while locked shows whether the enable wrongly discards alignment, or whether power-down leaves stale counts that cause an early relock.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;

   // Start bit and stop bit added to each payload word.
   localparam int unsigned FRAMING_BITS = 2;

   typedef enum logic {
      ALN_HUNT = 1'b0,
      ALN_LOCK = 1'b1
   } aln_state_t;

   // Offset that comes one step before 'idx' in a frame of 'width' bits.
   function automatic int unsigned prior_offset(input int unsigned idx,
                                                input int unsigned width);
      return (idx == 0) ? (width - 1) : (idx - 1);
   endfunction

endpackage

// File: rtl/fa_edge_tracker.sv
module fa_edge_tracker #(
   parameter int unsigned FRAME_W     = 20,
   parameter int unsigned LOCK_FRAMES = 4,
   localparam int unsigned PH_W       = $clog2(FRAME_W),
   localparam int unsigned CNT_W      = $clog2(LOCK_FRAMES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ser_bit,
   output logic [PH_W-1:0]    ph,
   output logic               edge_now,
   output logic [FRAME_W-1:0] sat_vec,
   output logic [FRAME_W-1:0] rep_vec
);

   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_FRAMES);
   localparam logic [CNT_W-1:0] CNT_REP = CNT_W'(2);

   logic [PH_W-1:0] ph_q;
   logic            prev_q;

   // Free-running bit offset within an assumed 20-bit frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         prev_q <= 1'b0;
      end else if (clr) begin
         ph_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         ph_q   <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
         prev_q <= ser_bit;
      end
   end

   assign ph       = ph_q;
   assign edge_now = ser_bit & ~prev_q;

   // One consistency counter for every offset.
   for (genvar g = 0; g < FRAME_W; g++) begin : g_off
      logic [CNT_W-1:0] run_q;
      logic             my_turn;

      assign my_turn = (ph_q == PH_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
         end else if (clr) begin
            run_q <= '0;
         end else if (my_turn) begin
            if (!edge_now)
               run_q <= '0;
            else if (run_q != CNT_TOP)
               run_q <= run_q + CNT_W'(1);
         end
      end

      assign sat_vec[g] = (run_q == CNT_TOP);
      assign rep_vec[g] = (run_q >= CNT_REP);
   end

endmodule

// File: rtl/fa_lock_ctrl.sv
module fa_lock_ctrl
   import frame_align_pkg::*;
#(
   parameter int unsigned FRAME_W    = 20,
   parameter int unsigned MISS_LIMIT = 2,
   localparam int unsigned PH_W      = $clog2(FRAME_W),
   localparam int unsigned MISS_W    = $clog2(MISS_LIMIT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [PH_W-1:0]    ph,
   input  logic               edge_now,
   input  logic [FRAME_W-1:0] sat_vec,
   input  logic [FRAME_W-1:0] rep_vec,
   output logic               locked,
   output logic [PH_W-1:0]    lock_off,
   output logic               lost_pulse,
   output logic               drop_now
);

   localparam logic [PH_W-1:0]    PH_LAST   = PH_W'(FRAME_W - 1);
   localparam logic [MISS_W-1:0]  MISS_LAST = MISS_W'(MISS_LIMIT - 1);
   localparam logic [FRAME_W-1:0] VEC_ONE   = FRAME_W'(1);

   aln_state_t        st_q;
   logic [PH_W-1:0]   off_q;
   logic [MISS_W-1:0] miss_q;
   logic              lost_q;

   logic              one_sat;
   logic              no_rival;
   logic              can_lock;
   logic [PH_W-1:0]   sat_idx;
   logic              at_boundary;

   // Exactly one saturated offset, and no other offset repeating.
   assign one_sat  = (sat_vec != '0) && ((sat_vec & (sat_vec - VEC_ONE)) == '0);
   assign no_rival = ((rep_vec & ~sat_vec) == '0);
   assign can_lock = one_sat && no_rival && (ph == PH_LAST);

   always_comb begin
      sat_idx = '0;
      for (int i = 0; i < FRAME_W; i++) begin
         if (sat_vec[i]) sat_idx = PH_W'(i);
      end
   end

   assign at_boundary = (st_q == ALN_LOCK) && (ph == off_q);
   assign drop_now    = at_boundary && !edge_now && (miss_q == MISS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ALN_HUNT;
         off_q  <= '0;
         miss_q <= '0;
         lost_q <= 1'b0;
      end else if (clr) begin
         st_q   <= ALN_HUNT;
         off_q  <= '0;
         miss_q <= '0;
         lost_q <= 1'b0;
      end else begin
         lost_q <= 1'b0;
         unique case (st_q)
            ALN_HUNT: begin
               if (can_lock) begin
                  st_q   <= ALN_LOCK;
                  off_q  <= sat_idx;
                  miss_q <= '0;
               end
            end
            ALN_LOCK: begin
               if (at_boundary) begin
                  if (edge_now) begin
                     miss_q <= '0;
                  end else if (drop_now) begin
                     st_q   <= ALN_HUNT;
                     miss_q <= '0;
                     lost_q <= 1'b1;
                  end else begin
                     miss_q <= miss_q + MISS_W'(1);
                  end
               end
            end
            default: st_q <= ALN_HUNT;
         endcase
      end
   end

   assign locked     = (st_q == ALN_LOCK);
   assign lock_off   = off_q;
   assign lost_pulse = lost_q;

endmodule

// File: rtl/fa_word_assembler.sv
module fa_word_assembler
   import frame_align_pkg::*;
#(
   parameter int unsigned DATA_W    = 18,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned FRAME_W  = DATA_W + FRAMING_BITS,
   localparam int unsigned PH_W     = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ser_bit,
   input  logic [PH_W-1:0]   ph,
   input  logic [PH_W-1:0]   lock_off,
   input  logic              locked,
   output logic [DATA_W-1:0] word,
   output logic              word_stb
);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_d;
   logic [DATA_W-1:0] word_q;
   logic              stb_q;
   logic [PH_W-1:0]   stop_ph;

   // The stop bit sits one offset before the locked start bit.
   assign stop_ph = PH_W'(prior_offset(int'(lock_off), FRAME_W));

   if (LSB_FIRST) begin : g_lsb
      assign sh_d = {ser_bit, sh_q[DATA_W-1:1]};
   end else begin : g_msb
      assign sh_d = {sh_q[DATA_W-2:0], ser_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         word_q <= '0;
         stb_q  <= 1'b0;
      end else if (clr) begin
         sh_q   <= '0;
         word_q <= '0;
         stb_q  <= 1'b0;
      end else begin
         sh_q  <= sh_d;
         stb_q <= 1'b0;
         if (locked && (ph == stop_ph)) begin
            word_q <= sh_q;
            stb_q  <= 1'b1;
         end
      end
   end

   assign word     = word_q;
   assign word_stb = stb_q;

endmodule

// File: rtl/frame_align_lock.sv
module frame_align_lock
   import frame_align_pkg::*;
#(
   parameter int unsigned DATA_W      = 18,
   parameter int unsigned LOCK_FRAMES = 4,
   parameter int unsigned MISS_LIMIT  = 2,
   parameter bit          LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_pwr_n,
   input  logic              rx_en,
   input  logic              ser_bit,
   output logic [DATA_W-1:0] word_o,
   output logic              word_stb,
   output logic              lock_n,
   output logic              lock_lost
);

   localparam int unsigned FRAME_W = DATA_W + FRAMING_BITS;
   localparam int unsigned PH_W    = $clog2(FRAME_W);

   if (DATA_W < 2) begin : g_chk_width
      $error("DATA_W must be at least 2");
   end
   if (LOCK_FRAMES < 3) begin : g_chk_lock
      $error("LOCK_FRAMES must be at least 3");
   end
   if (MISS_LIMIT < 1) begin : g_chk_miss
      $error("MISS_LIMIT must be at least 1");
   end

   logic               hold_clr;
   logic               drop_now;
   logic               trk_clr;
   logic [PH_W-1:0]    ph;
   logic               edge_now;
   logic [FRAME_W-1:0] sat_vec;
   logic [FRAME_W-1:0] rep_vec;
   logic               locked;
   logic [PH_W-1:0]    lock_off;
   logic               lost_pulse;
   logic [DATA_W-1:0]  word_raw;
   logic               stb_raw;
   logic               out_on;

   assign hold_clr = !rx_pwr_n;
   assign trk_clr  = hold_clr | drop_now;

   fa_edge_tracker #(
      .FRAME_W    (FRAME_W),
      .LOCK_FRAMES(LOCK_FRAMES)
   ) trk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (trk_clr),
      .ser_bit (ser_bit),
      .ph      (ph),
      .edge_now(edge_now),
      .sat_vec (sat_vec),
      .rep_vec (rep_vec)
   );

   fa_lock_ctrl #(
      .FRAME_W   (FRAME_W),
      .MISS_LIMIT(MISS_LIMIT)
   ) ctl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (hold_clr),
      .ph        (ph),
      .edge_now  (edge_now),
      .sat_vec   (sat_vec),
      .rep_vec   (rep_vec),
      .locked    (locked),
      .lock_off  (lock_off),
      .lost_pulse(lost_pulse),
      .drop_now  (drop_now)
   );

   fa_word_assembler #(
      .DATA_W   (DATA_W),
      .LSB_FIRST(LSB_FIRST)
   ) asm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hold_clr),
      .ser_bit (ser_bit),
      .ph      (ph),
      .lock_off(lock_off),
      .locked  (locked),
      .word    (word_raw),
      .word_stb(stb_raw)
   );

   assign out_on    = rx_en & rx_pwr_n;
   assign word_o    = out_on ? word_raw : '0;
   assign word_stb  = out_on & stb_raw;
   assign lock_n    = ~(locked & rx_pwr_n);
   assign lock_lost = lost_pulse & rx_pwr_n;

endmodule

// File: rtl/frame_align_lock_chk.sv
module frame_align_lock_chk #(
   parameter int unsigned DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_pwr_n,
   input logic              rx_en,
   input logic [DATA_W-1:0] word_o,
   input logic              word_stb,
   input logic              lock_n,
   input logic              lock_lost
);

   localparam int unsigned FRAME_W = DATA_W + 2;
   localparam int unsigned GAP_W   = $clog2(FRAME_W + 1);

   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= GAP_W'(FRAME_W);
      else if (word_stb)
         gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(FRAME_W))
         gap_q <= gap_q + GAP_W'(1);
   end

   // R1: strobes are a frame apart
   assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> (gap_q >= GAP_W'(FRAME_W)));

   // R7: no word without lock
   assert_stb_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |-> !lock_n);

   // R6: loss pulse lasts one cycle and coincides with the flag rising
   assert_lost_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_lost |=> !lock_lost);
   assert_lost_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_lost |-> lock_n);

   // R8: enable low silences the word path
   assert_en_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> (!word_stb && (word_o == '0)));

   // R9: power-down silences everything
   assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_pwr_n |-> (lock_n && !word_stb && (word_o == '0)));

   // R10: lock can only appear while powered
   assert_lock_powered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_n) |-> rx_pwr_n);

endmodule

bind frame_align_lock frame_align_lock_chk #(.DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_pwr_n (rx_pwr_n),
   .rx_en    (rx_en),
   .word_o   (word_o),
   .word_stb (word_stb),
   .lock_n   (lock_n),
   .lock_lost(lock_lost)
);

// File: tb/frame_align_lock_tb_top.sv
`timescale 1ns/1ps
module frame_align_lock_tb_top;

   localparam int DW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_pwr_n = 1'b1;
   logic          rx_en = 1'b1;
   logic          ser_bit = 1'b0;
   logic [DW-1:0] word_o;
   logic          word_stb;
   logic          lock_n;
   logic          lock_lost;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [DW-1:0] rec [0:31];
   int            rec_n = 0;
   int            lost_n = 0;

   always #2.5 clk = ~clk;

   frame_align_lock dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_pwr_n (rx_pwr_n),
      .rx_en    (rx_en),
      .ser_bit  (ser_bit),
      .word_o   (word_o),
      .word_stb (word_stb),
      .lock_n   (lock_n),
      .lock_lost(lock_lost)
   );

   // Recorder samples just after each rising edge.
   always begin
      @(posedge clk);
      #1;
      if (word_stb) begin
         if (rec_n < 32) rec[rec_n] = word_o;
         rec_n++;
      end
      if (lock_lost) lost_n++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_rec();
      rec_n  = 0;
      lost_n = 0;
   endtask

   // Drive one bit at the current falling edge, hold for one cycle.
   task automatic send_bit(input logic b);
      ser_bit = b;
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [DW-1:0] d, input logic start);
      send_bit(start);
      for (int i = 0; i < DW; i++) send_bit(d[i]);
      send_bit(1'b0);
   endtask

   function automatic logic [DW-1:0] sync_word();
      return {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
   endfunction

   function automatic logic [DW-1:0] walk_word(input int k);
      return DW'(1) << (k % DW);
   endfunction

   task automatic t_reset();
      check(lock_n == 1'b1, "R11 lock_n", int'(lock_n), 1);
      check(word_stb == 1'b0, "R11 word_stb", int'(word_stb), 0);
      check(lock_lost == 1'b0, "R11 lock_lost", int'(lock_lost), 0);
      check(word_o == '0, "R11 word_o", int'(word_o), 0);
   endtask

   task automatic t_sync_lock();
      for (int i = 0; i < 3; i++) send_frame(sync_word(), 1'b1);
      check(lock_n == 1'b1, "R2 early lock", int'(lock_n), 1);
      for (int i = 0; i < 2; i++) send_frame(sync_word(), 1'b1);
      check(lock_n == 1'b0, "R2 lock after sync", int'(lock_n), 0);
   endtask

   task automatic t_data();
      logic [DW-1:0] d [0:4];
      d[0] = 18'h2A5C3; d[1] = 18'h00001; d[2] = 18'h20000;
      d[3] = 18'h3FFFF; d[4] = 18'h1B0E4;
      clear_rec();
      for (int i = 0; i < 5; i++) send_frame(d[i], 1'b1);
      check(rec_n == 5, "R1 word count", rec_n, 5);
      for (int i = 0; i < 5; i++)
         check(rec[i] == d[i], "R1 word value", int'(rec[i]), int'(d[i]));
      check(lock_n == 1'b0, "R7 lock held with data", int'(lock_n), 0);
   endtask

   task automatic t_enable();
      logic [DW-1:0] a, b;
      a = 18'h0F0F0; b = 18'h31337;
      rx_en = 1'b0;
      clear_rec();
      for (int i = 0; i < 3; i++) send_frame(18'h15555, 1'b1);
      check(rec_n == 0, "R8 no strobe when disabled", rec_n, 0);
      check(word_o == '0, "R8 word quiet", int'(word_o), 0);
      check(lock_n == 1'b0, "R8 lock kept", int'(lock_n), 0);
      rx_en = 1'b1;
      clear_rec();
      send_frame(a, 1'b1);
      send_frame(b, 1'b1);
      check(rec_n == 2, "R8 resume count", rec_n, 2);
      check(rec[0] == a && rec[1] == b, "R8 resume data", int'(rec[0]), int'(a));
   endtask

   task automatic t_single_miss();
      clear_rec();
      send_frame(sync_word(), 1'b1);
      send_frame('0, 1'b0);
      send_frame(sync_word(), 1'b1);
      send_frame(sync_word(), 1'b1);
      check(lock_n == 1'b0, "R5 lock after one miss", int'(lock_n), 0);
      check(lost_n == 0, "R5 no loss pulse", lost_n, 0);
   endtask

   task automatic t_double_miss();
      clear_rec();
      send_frame('0, 1'b0);
      send_frame('0, 1'b0);
      check(lock_n == 1'b1, "R6 lock dropped", int'(lock_n), 1);
      check(lost_n == 1, "R6 one loss pulse", lost_n, 1);
   endtask

   task automatic t_rmt();
      clear_rec();
      for (int i = 0; i < 10; i++) send_frame(18'h00002, 1'b1);
      check(lock_n == 1'b1, "R4 no lock with two steps", int'(lock_n), 1);
      check(rec_n == 0, "R7 no words unlocked", rec_n, 0);
      for (int i = 0; i < 6; i++) send_frame(sync_word(), 1'b1);
      check(lock_n == 1'b0, "R4 lock after pattern change", int'(lock_n), 0);
   endtask

   task automatic t_power();
      rx_pwr_n = 1'b0;
      #1;
      check(lock_n == 1'b1, "R9 lock_n forced", int'(lock_n), 1);
      check(word_stb == 1'b0 && word_o == '0, "R9 outputs quiet", int'(word_o), 0);
      @(negedge clk);
      clear_rec();
      for (int i = 0; i < 2; i++) send_frame(sync_word(), 1'b1);
      check(rec_n == 0, "R9 no words while down", rec_n, 0);
      rx_pwr_n = 1'b1;
      for (int i = 0; i < 2; i++) send_frame(walk_word(i), 1'b1);
      check(lock_n == 1'b1, "R10 hunting after power-up", int'(lock_n), 1);
   endtask

   task automatic t_random_lock();
      logic [DW-1:0] x, y;
      for (int i = 2; i < 8; i++) send_frame(walk_word(i), 1'b1);
      check(lock_n == 1'b0, "R3 lock on varying data", int'(lock_n), 0);
      x = walk_word(9); y = walk_word(10);
      clear_rec();
      send_frame(x, 1'b1);
      send_frame(y, 1'b1);
      check(rec_n == 2 && rec[0] == x && rec[1] == y, "R3 data after lock",
            int'(rec[0]), int'(x));
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_sync_lock();
      t_data();
      t_enable();
      t_single_miss();
      t_double_miss();
      t_rmt();
      t_power();
      t_random_lock();
      done = 1'b1;
      finish_run();
   end

endmodule